// File: doc/BRIEF.md
# Lock-Aware Replacement Way Chooser

This block decides which way of a four-way set-associative cache gets refilled when a lookup misses. For every set it holds a least-recently-used order, and it refreshes that order on each access. Two of the four ways, ways 2 and 3, can be pinned by software. A pinned way is taken out of the normal replacement choice. A prefetch miss can instead be steered straight into a pinned way, so that the contents of a locked region can be loaded on purpose.

On each cycle the surrounding cache controller may present one access: a set index, a hit or miss indication, the way that hit, and whether the access came from a prefetch instruction. It also drives the cache-lock bit from the processor status word and a control word that carries the pin and steer bits for ways 2 and 3. One cycle after a miss, the block returns the way to refill, both as a two-bit number and as a one-hot vector. The same refill marks that way as most recently used. Tag and data arrays, the line fill and the bus side all belong to the controller.

Top module: `lockable_victim_sel`

## Requirements
- R1: After reset `vict_valid` and `load_conflict` are 0, and every set orders its ways from oldest to newest as 0, 1, 2, 3, so the first unrestricted miss in any set picks way 0.
- R2: A miss (`acc_valid`=1, `acc_hit`=0) sets `vict_valid` to 1 in the following cycle, with `vict_way` giving the way and `vict_onehot` having bit `vict_way` as its only set bit. In a cycle after a hit or an idle cycle, `vict_valid` is 0.
- R3: When `cache_lock_en`=0, a prefetch miss picks the least recently used of all four ways, whatever the control word holds.
- R4: Every hit makes the hit way the most recent in its set, and every miss makes the chosen way the most recent. Each set keeps its own order, independent of the others.
- R5: When `cache_lock_en`=1 and both pin bits (control bits 0 and 8) are 0, a prefetch miss picks the least recently used of all four ways.
- R6: When `cache_lock_en`=1, a prefetch miss picks way 2 if control bit 0 (pin way 2) is 1, bit 1 (steer to way 2) is 1, and bit 9 (steer to way 3) is 0.
- R7: When `cache_lock_en`=1, a prefetch miss picks way 3 if control bit 8 (pin way 3) is 1, bit 9 (steer to way 3) is 1, and bit 1 (steer to way 2) is 0.
- R8: Pinned ways are excluded from the choice, and the least recently used of the remaining ways is picked. This applies to every non-prefetch miss, and to any prefetch miss with `cache_lock_en`=1 that R6 and R7 do not steer. Pinning way 2 leaves {0,1,3}, pinning way 3 leaves {0,1,2}, and pinning both leaves {0,1}.
- R9: `load_conflict` is 1 in the cycle after a cycle in which control bits 1 and 9 are both 1, and 0 otherwise. In that state neither steer applies, so the choice follows R3 or R8.
- R10: Control bits other than 0, 1, 8 and 9 have no effect on the chosen way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | 1 = the access hit, 0 = it missed |
| acc_way | input | 2 | Way that hit (used only when `acc_hit`=1) |
| acc_set | input | IDX_W | Set index of the access |
| acc_pref | input | 1 | The access comes from a prefetch instruction |
| cache_lock_en | input | 1 | Cache-lock bit of the processor status word |
| ctl_word | input | CTL_W | Control word: bit 0 pins way 2, bit 1 steers to way 2, bit 8 pins way 3, bit 9 steers to way 3 |
| vict_valid | output | 1 | A refill way is returned this cycle |
| vict_way | output | 2 | Encoded refill way |
| vict_onehot | output | 4 | One-hot refill way |
| load_conflict | output | 1 | Both steer bits were set in the previous cycle |

## Verification
On every cycle the checker confirms the timing of `vict_valid` after a miss and its absence otherwise, the agreement between the encoded and one-hot results, and the tracking of `load_conflict`. It also confirms that a pinned way never comes back from a non-prefetch miss and that the two steered cases return way 2 or way 3. Which way is actually the oldest depends on the whole access history of a set, and only the bench's reference order can show it. The bench sweeps every combination of the pin, steer, prefetch and cache-lock inputs with hits and misses spread across sets. It also shows that unrelated control bits are ignored and that a second reset restores the starting order.

// File: rtl/vsel_pkg.sv
`timescale 1ns/1ps
package vsel_pkg;

  localparam int NWAYS = 4;
  localparam int PAIRS = NWAYS * (NWAYS - 1) / 2;

  // control word field positions (decoded by software, so fixed)
  localparam int CTL_PIN2   = 0;
  localparam int CTL_STEER2 = 1;
  localparam int CTL_PIN3   = 8;
  localparam int CTL_STEER3 = 9;

  typedef logic [PAIRS-1:0] order_t;   // bit set: lower way is more recent
  typedef logic [1:0]       way_t;
  typedef logic [NWAYS-1:0] wmask_t;

  // pair (i,j), i<j, mapped to its bit in the order matrix
  function automatic int pair_bit(input int i, input int j);
    int k;
    k = 0;
    for (int a = 0; a < NWAYS; a++) begin
      for (int b = a + 1; b < NWAYS; b++) begin
        if (a == i && b == j) pair_bit = k;
        k++;
      end
    end
  endfunction

  // true when way x was used longer ago than way y
  function automatic logic older(input order_t m, input int x, input int y);
    if (x < y) older = ~m[pair_bit(x, y)];
    else       older =  m[pair_bit(y, x)];
  endfunction

  // mark way w as most recent
  function automatic order_t touch(input order_t m, input way_t w);
    order_t r;
    r = m;
    for (int a = 0; a < NWAYS; a++) begin
      for (int b = a + 1; b < NWAYS; b++) begin
        if (a == int'(w)) r[pair_bit(a, b)] = 1'b1;
        if (b == int'(w)) r[pair_bit(a, b)] = 1'b0;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/vsel_order_store.sv
`timescale 1ns/1ps
module vsel_order_store
  import vsel_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             upd_en,
  input  way_t             upd_way,
  output order_t           cur_order
);

  // order matrices kept in a plain array without reset so it can map to RAM
  order_t           mem [SETS];
  logic [SETS-1:0]  fresh_n;   // 0 = set still in its reset order
  order_t           raw;

  assign raw       = mem[set_idx];
  assign cur_order = fresh_n[set_idx] ? raw : '0;

  always_ff @(posedge clk) begin
    if (upd_en) mem[set_idx] <= touch(cur_order, upd_way);
  end

  always_ff @(posedge clk) begin
    if (rst)         fresh_n          <= '0;
    else if (upd_en) fresh_n[set_idx] <= 1'b1;
  end

endmodule

// File: rtl/vsel_policy.sv
`timescale 1ns/1ps
module vsel_policy
  import vsel_pkg::*;
(
  input  logic   is_pref,
  input  logic   lock_en,
  input  logic   pin2,
  input  logic   steer2,
  input  logic   pin3,
  input  logic   steer3,
  output wmask_t cand,
  output logic   force_en,
  output way_t   force_way,
  output logic   conflict
);

  logic pref_locked;
  logic go2, go3;

  assign pref_locked = is_pref & lock_en;
  assign go2         = pref_locked & pin2 & steer2 & ~steer3;
  assign go3         = pref_locked & pin3 & steer3 & ~steer2;
  assign conflict    = steer2 & steer3;

  always_comb begin
    force_en  = go2 | go3;
    force_way = go3 ? 2'd3 : 2'd2;
    cand      = '1;
    // prefetch with cache lock off ignores the pins entirely
    if (!(is_pref && !lock_en)) begin
      if (pin2) cand[2] = 1'b0;
      if (pin3) cand[3] = 1'b0;
    end
  end

endmodule

// File: rtl/vsel_oldest_pick.sv
`timescale 1ns/1ps
module vsel_oldest_pick
  import vsel_pkg::*;
(
  input  order_t order,
  input  wmask_t cand,
  output way_t   pick
);

  wmask_t is_oldest;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    always_comb begin
      is_oldest[w] = cand[w];
      for (int k = 0; k < NWAYS; k++) begin
        if (k != w && cand[k] && !older(order, w, k)) is_oldest[w] = 1'b0;
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (is_oldest[w]) pick = way_t'(w);
    end
  end

endmodule

// File: rtl/lockable_victim_sel.sv
`timescale 1ns/1ps
module lockable_victim_sel
  import vsel_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int CTL_W = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [1:0]       acc_way,
  input  logic [IDX_W-1:0] acc_set,
  input  logic             acc_pref,
  input  logic             cache_lock_en,
  input  logic [CTL_W-1:0] ctl_word,
  output logic             vict_valid,
  output logic [1:0]       vict_way,
  output logic [3:0]       vict_onehot,
  output logic             load_conflict
);

  order_t cur_order;
  wmask_t cand;
  logic   force_en, conflict, miss;
  way_t   force_way, lru_pick, chosen, upd_way;
  logic   ctl_unused;

  assign ctl_unused = ^ctl_word;
  assign miss       = acc_valid & ~acc_hit;

  vsel_policy u_pol (
    .is_pref   (acc_pref),
    .lock_en   (cache_lock_en),
    .pin2      (ctl_word[CTL_PIN2]),
    .steer2    (ctl_word[CTL_STEER2]),
    .pin3      (ctl_word[CTL_PIN3]),
    .steer3    (ctl_word[CTL_STEER3]),
    .cand      (cand),
    .force_en  (force_en),
    .force_way (force_way),
    .conflict  (conflict)
  );

  vsel_order_store #(.SETS(SETS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .set_idx   (acc_set),
    .upd_en    (acc_valid),
    .upd_way   (upd_way),
    .cur_order (cur_order)
  );

  vsel_oldest_pick u_pick (
    .order (cur_order),
    .cand  (cand),
    .pick  (lru_pick)
  );

  assign chosen  = force_en ? force_way : lru_pick;
  assign upd_way = acc_hit ? acc_way : chosen;

  always_ff @(posedge clk) begin
    if (rst) begin
      vict_valid    <= 1'b0;
      vict_way      <= '0;
      vict_onehot   <= '0;
      load_conflict <= 1'b0;
    end else begin
      vict_valid    <= miss;
      load_conflict <= conflict;
      if (miss) begin
        vict_way    <= chosen;
        vict_onehot <= wmask_t'(1) << chosen;
      end
    end
  end

endmodule

// File: rtl/vsel_checks.sv
`timescale 1ns/1ps
module vsel_checks #(
  parameter int CTL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_hit,
  input logic             acc_pref,
  input logic             cache_lock_en,
  input logic [CTL_W-1:0] ctl_word,
  input logic             vict_valid,
  input logic [1:0]       vict_way,
  input logic [3:0]       vict_onehot,
  input logic             load_conflict
);

  logic miss, pin2, steer2, pin3, steer3;
  assign miss   = acc_valid && !acc_hit;
  assign pin2   = ctl_word[0];
  assign steer2 = ctl_word[1];
  assign pin3   = ctl_word[8];
  assign steer3 = ctl_word[9];

  a_r2_result_follows_miss: assert property (@(posedge clk) disable iff (rst)
    miss |=> vict_valid);
  a_r2_quiet_without_miss: assert property (@(posedge clk) disable iff (rst)
    !miss |=> !vict_valid);
  a_r2_forms_agree: assert property (@(posedge clk) disable iff (rst)
    vict_valid |-> ($countones(vict_onehot) == 1 && vict_onehot[vict_way]));
  a_r8_pin2_spared: assert property (@(posedge clk) disable iff (rst)
    (miss && !acc_pref && pin2) |=> vict_way != 2'd2);
  a_r8_pin3_spared: assert property (@(posedge clk) disable iff (rst)
    (miss && !acc_pref && pin3) |=> vict_way != 2'd3);
  a_r6_steer_way2: assert property (@(posedge clk) disable iff (rst)
    (miss && acc_pref && cache_lock_en && pin2 && steer2 && !steer3) |=> vict_way == 2'd2);
  a_r7_steer_way3: assert property (@(posedge clk) disable iff (rst)
    (miss && acc_pref && cache_lock_en && pin3 && steer3 && !steer2) |=> vict_way == 2'd3);
  a_r9_conflict_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> load_conflict == $past(steer2 && steer3));

endmodule

bind lockable_victim_sel vsel_checks #(.CTL_W(CTL_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_hit       (acc_hit),
  .acc_pref      (acc_pref),
  .cache_lock_en (cache_lock_en),
  .ctl_word      (ctl_word),
  .vict_valid    (vict_valid),
  .vict_way      (vict_way),
  .vict_onehot   (vict_onehot),
  .load_conflict (load_conflict)
);

// File: tb/sim_lockable_victim_sel.sv
`timescale 1ns/1ps
module sim_lockable_victim_sel;

  localparam int SETS = 16;
  localparam int IW   = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_valid, acc_hit, acc_pref, cache_lock_en;
  logic [1:0]    acc_way;
  logic [IW-1:0] acc_set;
  logic [15:0]   ctl_word;
  logic          vict_valid, load_conflict;
  logic [1:0]    vict_way;
  logic [3:0]    vict_onehot;

  int stamp [SETS][4];
  int now;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  lockable_victim_sel #(.SETS(SETS), .CTL_W(16)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_way(acc_way), .acc_set(acc_set), .acc_pref(acc_pref),
    .cache_lock_en(cache_lock_en), .ctl_word(ctl_word),
    .vict_valid(vict_valid), .vict_way(vict_way),
    .vict_onehot(vict_onehot), .load_conflict(load_conflict)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) stamp[s][w] = w;
    now = 4;
  endtask

  function automatic int expect_way(int s, bit pref, bit cl, logic [15:0] c);
    bit [3:0] cand;
    int best;
    cand = 4'b1111;
    if (pref && cl && c[0] && c[1] && !c[9]) return 2;
    if (pref && cl && c[8] && c[9] && !c[1]) return 3;
    if (!(pref && !cl)) begin
      if (c[0]) cand[2] = 1'b0;
      if (c[8]) cand[3] = 1'b0;
    end
    best = -1;
    for (int w = 0; w < 4; w++)
      if (cand[w] && (best < 0 || stamp[s][w] < stamp[s][best])) best = w;
    return best;
  endfunction

  function automatic string pick_tag(bit pref, bit cl, logic [15:0] c);
    if (c[1] && c[9])                      return "R9";
    if (pref && !cl)                       return "R3";
    if (pref && cl && c[0] && c[1])        return "R6";
    if (pref && cl && c[8] && c[9])        return "R7";
    if (c[0] || c[8])                      return "R8";
    if (pref && cl)                        return "R5";
    return "R4";
  endfunction

  task automatic access(input int s, input bit hit, input int hw, input bit pref,
                        input bit cl, input logic [15:0] c, input string tag);
    int    exp;
    string t;
    @(negedge clk);
    acc_valid = 1'b1; acc_hit = hit; acc_way = 2'(hw); acc_set = IW'(s);
    acc_pref = pref; cache_lock_en = cl; ctl_word = c;
    exp = hit ? hw : expect_way(s, pref, cl, c);
    @(negedge clk);
    if (hit) begin
      check(vict_valid == 1'b0, "R2", int'(vict_valid), 0);
    end else begin
      t = (tag != "") ? tag : pick_tag(pref, cl, c);
      check(vict_valid == 1'b1, "R2", int'(vict_valid), 1);
      check(int'(vict_way) == exp, t, int'(vict_way), exp);
      check(vict_onehot == 4'(1 << exp), "R2", int'(vict_onehot), 1 << exp);
    end
    check(load_conflict == (c[1] & c[9]), "R9", int'(load_conflict), int'(c[1] & c[9]));
    stamp[s][exp] = now;
    now++;
    acc_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check(vict_valid == 1'b0, "R1", int'(vict_valid), 0);
    check(load_conflict == 1'b0, "R1", int'(load_conflict), 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_hit = 1'b0; acc_way = '0; acc_set = '0;
    acc_pref = 1'b0; cache_lock_en = 1'b0; ctl_word = '0;
    do_reset();

    // R1: fresh sets start from way 0
    access(5, 1'b0, 0, 1'b0, 1'b0, 16'h0000, "R1");
    access(9, 1'b0, 0, 1'b1, 1'b1, 16'h0000, "R1");

    // R3..R9 and R4: sweep every pin/steer/prefetch/lock combination
    for (int combo = 0; combo < 64; combo++) begin
      logic [15:0] c;
      c = 16'((combo * 16'h1357) & 16'hFCFC);
      c[0] = combo[0]; c[1] = combo[1]; c[8] = combo[2]; c[9] = combo[3];
      for (int step = 0; step < 6; step++) begin
        access((combo * 3 + step) % SETS, (step % 3) == 1, (combo + step) % 4,
               combo[4], combo[5], c, "");
      end
    end

    // R4: repeated hits reshape the order within one set only
    for (int i = 0; i < 4; i++) access(2, 1'b1, 3 - i, 1'b0, 1'b0, 16'h0000, "R4");
    for (int i = 0; i < 4; i++) access(2, 1'b0, 0, 1'b0, 1'b0, 16'h0000, "R4");

    // R10: only unrelated control bits set
    for (int i = 0; i < 8; i++) access(i % 3 + 11, 1'b0, 0, i[0], 1'b1, 16'hFCFC, "R10");

    // R1: a second reset restores the starting order
    do_reset();
    for (int s = 0; s < SETS; s++) access(s, 1'b0, 0, 1'b0, 1'b0, 16'h0000, "R1");

    finish_run();
  end

endmodule